// File: doc/BRIEF.md
# Smart Card Power Sequencer

This block brings a 5 V contact smart card up and down in a safe order. It watches a card-presence switch, filters it over a long debounce window, and waits for the host to pull its active-low command line low. It then switches on the card supply, the I/O path, the card clock and finally the reset path, with a fixed gap between each step. It takes the card down again in the reverse order when the host releases the command line or when any fault appears. Faults are card removal, a supply short, overtemperature, and a low level on either supply rail.

One active-low alarm output reports faults to the host. The block also produces the card clock, which is the system clock divided by one of two ratios. It passes the host reset-in level to the card only while the reset step is enabled. The system clock is assumed to run at twice the nominal reference rate (16 MHz for an 8 MHz reference). A divide ratio of 2 therefore gives the full reference rate, and a ratio of 4 gives half of it. Analog regulation, level shifting and the bidirectional data buffer are outside this block.

Top module: `card_act_seq`

## Requirements
- R1: A card counts as present only after `card_present` has been high, as seen after synchronisation, for `DEBOUNCE_CYCLES` consecutive clock cycles. A falling edge of `cmd_n` that arrives before that is ignored and is not remembered.
- R2: When idle, a high-to-low change on `cmd_n` starts activation if a card is present, no fault flag is high and the alarm is clear. `supply_en` rises on the third rising clock edge after `cmd_n` falls.
- R3: During activation, `io_en` rises `STEP_CYCLES` edges after `supply_en`. The card clock starts `STEP_CYCLES` edges after `io_en`. The reset path opens `STEP_CYCLES` edges after that.
- R4: Deactivation is triggered by `cmd_n` going high, by any of `flt_short`, `flt_hot`, `flt_vdd` or `flt_vddp` going high, or by `card_present` going low. On the third edge after the trigger the last enabled step is switched off.
- R5: Deactivation removes one step every `STEP_CYCLES` edges: reset, then clock, then I/O, then supply. It runs to completion even if `cmd_n` falls again during it, and that falling edge does not start a new activation.
- R6: While the clock step is on, `card_clk` is a square wave of period `DIV_FAST` cycles when `clk_sel` was high, or `DIV_SLOW` cycles when it was low, at the edge where the clock was enabled. Its first rise comes half a period after that edge. `clk_sel` changes while the clock runs have no effect. `card_clk` is low whenever the clock step is off.
- R7: `card_rst` equals `rst_in`, with two edges of latency, while the reset step is on, and is low otherwise.
- R8: A fault seen while the block is not idle drives `alarm_n` low on the third edge after the fault. It stays low until the block is idle and `cmd_n` is high, and then clears on the third edge after `cmd_n` rises.
- R9: While idle, `supply_en`, `io_en`, `card_clk` and `card_rst` are low. A fault flag that is high while idle blocks activation and does not set the alarm.
- R10: After reset all card-side outputs are low and `alarm_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, twice the reference rate |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_n | input | 1 | Host command, low requests an active card (asynchronous) |
| card_present | input | 1 | Card presence switch, high when inserted (asynchronous) |
| clk_sel | input | 1 | Card clock ratio select, high picks the fast ratio (asynchronous) |
| rst_in | input | 1 | Host card-reset level (asynchronous) |
| flt_short | input | 1 | Card supply short detected, high active (asynchronous) |
| flt_hot | input | 1 | Overtemperature, high active (asynchronous) |
| flt_vdd | input | 1 | Host-side supply low, high active (asynchronous) |
| flt_vddp | input | 1 | Card-feed supply low, high active (asynchronous) |
| supply_en | output | 1 | Card supply regulator enable |
| io_en | output | 1 | Card data path enable |
| card_clk | output | 1 | Divided card clock |
| card_rst | output | 1 | Card reset |
| alarm_n | output | 1 | Fault alarm, active low |

## Verification
Every asynchronous input reaches the sequencer through two flops, so any command or fault change has its effect on the third rising edge. The reset-in path adds one edge less. Once started, each activation or deactivation step lands a fixed multiple of `STEP_CYCLES` edges later. The bench counts rising edges from the negedge at which it drives a stimulus, and samples each output at every following negedge. It compares the output with a value computed from that edge count, the step spacing and the divide ratio. So a step that comes one edge early or late is flagged at the exact cycle. The alarm set and clear instants are checked at edges two and three after the stimulus, to pin down the third-edge rule.

// File: rtl/card_seq_pkg.sv
// Shared types and constants for the smart card power sequencer.
// Assumes a four-step thermometer of enables: supply, I/O, clock, reset.
package card_seq_pkg;

    localparam int NUM_STEPS = 4;
    localparam int STEP_SUPPLY = 0;
    localparam int STEP_IO = 1;
    localparam int STEP_CLK = 2;
    localparam int STEP_RST = 3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_UP   = 2'd1,
        ST_ON   = 2'd2,
        ST_DOWN = 2'd3
    } seq_state_t;

endpackage

// File: rtl/cs_sync.sv
// Two-flop synchronizer for a vector of independent asynchronous inputs.
// Assumes each bit is a slow level; no multi-bit coherence is implied.
module cs_sync #(
    parameter int WIDTH = 1,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    logic [WIDTH-1:0] meta_q;

    // Two stages per bit, loaded with the inactive level on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RESET_VAL;
            q_sync <= RESET_VAL;
        end else begin
            meta_q <= d_async;
            q_sync <= meta_q;
        end
    end

endmodule

// File: rtl/cs_debounce.sv
// Presence qualifier: reports a stable card only after the synchronized
// presence level has stayed high for COUNT cycles. Drops at once on a low.
// Assumes the input is already synchronized to clk.
module cs_debounce #(
    parameter int COUNT = 128000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic stable
);

    localparam int CW = $clog2(COUNT + 1);
    localparam logic [CW-1:0] LIMIT = CW'(COUNT);

    logic [CW-1:0] cnt_q;

    // Saturating run-length counter of the high level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!level) begin
            cnt_q <= '0;
        end else if (cnt_q != LIMIT) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign stable = level && (cnt_q == LIMIT);

endmodule

// File: rtl/cs_clkdiv.sv
// Card clock divider with two even ratios. The ratio is captured while the
// clock is stopped, so a select change never shortens a running phase.
// Assumes DIV_FAST and DIV_SLOW are even and at least 2.
module cs_clkdiv #(
    parameter int DIV_FAST = 2,
    parameter int DIV_SLOW = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic fast_sel,
    output logic card_clk
);

    localparam int HALF_F = DIV_FAST / 2;
    localparam int HALF_S = DIV_SLOW / 2;
    localparam int HALF_MAX = (HALF_F > HALF_S) ? HALF_F : HALF_S;
    localparam int CW = $clog2(HALF_MAX + 1);
    localparam logic [CW-1:0] HF = CW'(HALF_F);
    localparam logic [CW-1:0] HS = CW'(HALF_S);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] half_q;
    logic          phase_q;

    // Half-period counter; ratio latched only while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            half_q  <= HF;
            phase_q <= 1'b0;
        end else if (!run) begin
            cnt_q   <= '0;
            half_q  <= fast_sel ? HF : HS;
            phase_q <= 1'b0;
        end else if (cnt_q == half_q - 1'b1) begin
            cnt_q   <= '0;
            phase_q <= ~phase_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign card_clk = phase_q & run;

endmodule

// File: rtl/cs_fsm.sv
// Activation and deactivation sequencer. Holds a thermometer of step
// enables (supply, I/O, clock, reset), adds one step every STEP_CYCLES while
// activating and removes one every STEP_CYCLES while deactivating. Also
// keeps the latched fault alarm. Assumes synchronized inputs.
module cs_fsm
    import card_seq_pkg::*;
#(
    parameter int STEP_CYCLES = 1600
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_level,
    input  logic                 cmd_fall,
    input  logic                 card_in,
    input  logic                 fault_any,
    output logic [NUM_STEPS-1:0] step_en,
    output logic                 alarm
);

    localparam int TW = $clog2(STEP_CYCLES + 1);
    localparam logic [TW-1:0] T_LAST = TW'(STEP_CYCLES - 1);

    seq_state_t           state_q;
    logic [TW-1:0]        timer_q;
    logic [NUM_STEPS-1:0] en_q;
    logic                 alarm_q;
    logic                 fault_all;
    logic                 stop_req;
    logic                 start_ok;
    logic                 tick;

    // Fault set includes loss of the qualified card presence.
    always_comb begin
        fault_all = fault_any | ~card_in;
        stop_req  = cmd_level | fault_all;
        start_ok  = cmd_fall & card_in & ~fault_any & ~alarm_q;
        tick      = (timer_q == T_LAST);
    end

    // Step sequencer: state, step timer and enable thermometer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            timer_q <= '0;
            en_q    <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    timer_q <= '0;
                    en_q    <= '0;
                    if (start_ok) begin
                        en_q    <= NUM_STEPS'(1);
                        state_q <= ST_UP;
                    end
                end
                ST_UP: begin
                    if (stop_req) begin
                        timer_q <= '0;
                        en_q    <= en_q >> 1;
                        state_q <= en_q[STEP_IO] ? ST_DOWN : ST_IDLE;
                    end else if (tick) begin
                        timer_q <= '0;
                        en_q    <= {en_q[NUM_STEPS-2:0], 1'b1};
                        if (en_q[NUM_STEPS-2]) begin
                            state_q <= ST_ON;
                        end
                    end else begin
                        timer_q <= timer_q + 1'b1;
                    end
                end
                ST_ON: begin
                    timer_q <= '0;
                    if (stop_req) begin
                        en_q    <= en_q >> 1;
                        state_q <= ST_DOWN;
                    end
                end
                ST_DOWN: begin
                    if (tick) begin
                        timer_q <= '0;
                        en_q    <= en_q >> 1;
                        if (!en_q[STEP_IO]) begin
                            state_q <= ST_IDLE;
                        end
                    end else begin
                        timer_q <= timer_q + 1'b1;
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                    en_q    <= '0;
                    timer_q <= '0;
                end
            endcase
        end
    end

    // Alarm latch: set by a fault while busy, cleared idle with command high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alarm_q <= 1'b0;
        end else if (state_q != ST_IDLE && fault_all) begin
            alarm_q <= 1'b1;
        end else if (state_q == ST_IDLE && cmd_level) begin
            alarm_q <= 1'b0;
        end
    end

    assign step_en = en_q;
    assign alarm   = alarm_q;

endmodule

// File: rtl/card_act_seq.sv
// Top level of the smart card power sequencer. Synchronizes all host and
// card inputs, qualifies presence, runs the step sequencer, divides the card
// clock and gates the reset path. clk is assumed to be twice the reference.
module card_act_seq
    import card_seq_pkg::*;
#(
    parameter int DEBOUNCE_CYCLES = 128000,
    parameter int STEP_CYCLES = 1600,
    parameter int DIV_FAST = 2,
    parameter int DIV_SLOW = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_n,
    input  logic card_present,
    input  logic clk_sel,
    input  logic rst_in,
    input  logic flt_short,
    input  logic flt_hot,
    input  logic flt_vdd,
    input  logic flt_vddp,
    output logic supply_en,
    output logic io_en,
    output logic card_clk,
    output logic card_rst,
    output logic alarm_n
);

    localparam int NSYNC = 8;
    localparam int I_CMD = 7;
    localparam int I_PRES = 6;
    localparam int I_SEL = 5;
    localparam int I_RSTIN = 4;
    localparam logic [NSYNC-1:0] SYNC_RST = NSYNC'(1) << I_CMD;

    logic [NSYNC-1:0]     raw_in;
    logic [NSYNC-1:0]     syn;
    logic                 cmd_s;
    logic                 cmd_q;
    logic                 cmd_fall;
    logic                 card_in;
    logic                 fault_any;
    logic [NUM_STEPS-1:0] step_en;
    logic                 alarm;

    assign raw_in = {cmd_n, card_present, clk_sel, rst_in,
                     flt_short, flt_hot, flt_vdd, flt_vddp};

    cs_sync #(
        .WIDTH     (NSYNC),
        .RESET_VAL (SYNC_RST)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (raw_in),
        .q_sync  (syn)
    );

    assign cmd_s     = syn[I_CMD];
    assign fault_any = |syn[3:0];

    // Previous command level for high-to-low edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= 1'b1;
        end else begin
            cmd_q <= cmd_s;
        end
    end

    assign cmd_fall = cmd_q & ~cmd_s;

    cs_debounce #(
        .COUNT (DEBOUNCE_CYCLES)
    ) u_deb (
        .clk    (clk),
        .rst_n  (rst_n),
        .level  (syn[I_PRES]),
        .stable (card_in)
    );

    cs_fsm #(
        .STEP_CYCLES (STEP_CYCLES)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_level (cmd_s),
        .cmd_fall  (cmd_fall),
        .card_in   (card_in),
        .fault_any (fault_any),
        .step_en   (step_en),
        .alarm     (alarm)
    );

    cs_clkdiv #(
        .DIV_FAST (DIV_FAST),
        .DIV_SLOW (DIV_SLOW)
    ) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (step_en[STEP_CLK]),
        .fast_sel (syn[I_SEL]),
        .card_clk (card_clk)
    );

    assign supply_en = step_en[STEP_SUPPLY];
    assign io_en     = step_en[STEP_IO];
    assign card_rst  = step_en[STEP_RST] & syn[I_RSTIN];
    assign alarm_n   = ~alarm;

endmodule

// File: rtl/card_act_seq_chk.sv
// Property checker for the smart card power sequencer, bound to the top.
// Observes ports plus the qualified presence and synchronized command.
module card_act_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic supply_en,
    input logic io_en,
    input logic card_clk,
    input logic card_rst,
    input logic alarm_n,
    input logic card_in,
    input logic cmd_s
);

    AST_IO_NEEDS_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
        io_en |-> supply_en); // R3

    AST_CLK_NEEDS_IO: assert property (@(posedge clk) disable iff (!rst_n)
        card_clk |-> io_en); // R3

    AST_IO_RISES_AFTER_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(io_en) |-> $past(supply_en)); // R3

    AST_RST_NEEDS_IO: assert property (@(posedge clk) disable iff (!rst_n)
        card_rst |-> io_en); // R7

    AST_SUPPLY_OFF_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(supply_en) |-> $past(!io_en)); // R5

    AST_START_NEEDS_CARD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(supply_en) |-> $past(card_in)); // R1

    AST_ALARM_CLEAR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_n) |-> ($past(cmd_s) && !supply_en)); // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_en |-> (!io_en && !card_clk && !card_rst)); // R9

endmodule

bind card_act_seq card_act_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .supply_en (supply_en),
    .io_en     (io_en),
    .card_clk  (card_clk),
    .card_rst  (card_rst),
    .alarm_n   (alarm_n),
    .card_in   (card_in),
    .cmd_s     (cmd_s)
);

// File: tb/card_act_seq_tb.sv
// Self-checking bench: directed corner cases plus seeded random trials of
// activation interrupted by a host release or one of the fault sources.
module card_act_seq_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DEB = 20;
    localparam int STEP = 4;
    localparam int DIV_F = 2;
    localparam int DIV_S = 4;
    localparam int E_CLK = 3 + 2 * STEP;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_n = 1'b1;
    logic card_present = 1'b0;
    logic clk_sel = 1'b0;
    logic rst_in = 1'b0;
    logic flt_short = 1'b0;
    logic flt_hot = 1'b0;
    logic flt_vdd = 1'b0;
    logic flt_vddp = 1'b0;
    logic supply_en, io_en, card_clk, card_rst, alarm_n;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    card_act_seq #(
        .DEBOUNCE_CYCLES (DEB),
        .STEP_CYCLES     (STEP),
        .DIV_FAST        (DIV_F),
        .DIV_SLOW        (DIV_S)
    ) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_n        (cmd_n),
        .card_present (card_present),
        .clk_sel      (clk_sel),
        .rst_in       (rst_in),
        .flt_short    (flt_short),
        .flt_hot      (flt_hot),
        .flt_vdd      (flt_vdd),
        .flt_vddp     (flt_vddp),
        .supply_en    (supply_en),
        .io_en        (io_en),
        .card_clk     (card_clk),
        .card_rst     (card_rst),
        .alarm_n      (alarm_n)
    );

    task automatic check(input string req, input string what,
                         input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s at %0t: actual=%0b expected=%0b",
                     req, what, $time, act, exp);
        end
    endtask

    // Steps on after edge n of an activation started before edge 1.
    function automatic int up_lvl(input int n);
        int v;
        if (n < 3) return 0;
        v = 1 + (n - 3) / STEP;
        return (v > 4) ? 4 : v;
    endfunction

    // Steps on after edge n when the trigger is driven after edge d.
    function automatic int exp_lvl(input int n, input int d);
        int l0;
        int v;
        if (n < d + 3) return up_lvl(n);
        l0 = up_lvl(d + 2) - 1;
        v = l0 - (n - d - 3) / STEP;
        return (v < 0) ? 0 : v;
    endfunction

    function automatic logic exp_cclk(input int lvl, input int n, input int h);
        if (lvl < 3) return 1'b0;
        return logic'(((n - E_CLK) / h) % 2);
    endfunction

    task automatic wait_neg(input int k);
        for (int i = 0; i < k; i++) @(negedge clk);
    endtask

    // One activation interrupted after edge d by trigger kind.
    // kind 0 host release, 1..4 fault flags, 5 card removal.
    task automatic run_trial(input int kind, input int d,
                             input logic sel, input logic rv);
        int h;
        int nmax;
        int lvl;
        string rq;
        h = sel ? DIV_F / 2 : DIV_S / 2;
        nmax = d + 3 + 4 * STEP + 3;
        clk_sel = sel;
        rst_in = rv;
        wait_neg(4);
        cmd_n = 1'b0;
        for (int n = 1; n <= nmax; n++) begin
            @(negedge clk);
            lvl = exp_lvl(n, d);
            if (n <= 3) rq = "R2";
            else if (n < d + 3) rq = "R3";
            else if (n == d + 3) rq = "R4";
            else rq = "R5";
            check(rq, "supply_en", supply_en, lvl >= 1);
            check(rq, "io_en", io_en, lvl >= 2);
            check("R6", "card_clk", card_clk, exp_cclk(lvl, n, h));
            check("R7", "card_rst", card_rst, (lvl >= 4) && rv);
            check("R8", "alarm_n", alarm_n, !(kind != 0 && n >= d + 3));
            if (n == E_CLK + 1) clk_sel = ~sel; // R6 select ignored while running
            if (n == d) begin
                case (kind)
                    0: cmd_n = 1'b1;
                    1: flt_short = 1'b1;
                    2: flt_hot = 1'b1;
                    3: flt_vdd = 1'b1;
                    4: flt_vddp = 1'b1;
                    default: card_present = 1'b0;
                endcase
            end
            if (kind == 0 && n == d + 3 && up_lvl(d + 2) >= 2) cmd_n = 1'b0;
        end
        if (kind == 0) begin
            wait_neg(2 * STEP);
            check("R5", "no restart from edge during deactivation", supply_en, 1'b0);
            cmd_n = 1'b1;
            wait_neg(4);
        end else begin
            wait_neg(5);
            check("R8", "alarm held while command low", alarm_n, 1'b0);
            flt_short = 1'b0;
            flt_hot = 1'b0;
            flt_vdd = 1'b0;
            flt_vddp = 1'b0;
            card_present = 1'b1;
            cmd_n = 1'b1;
            wait_neg(2);
            check("R8", "alarm before third edge", alarm_n, 1'b0);
            wait_neg(1);
            check("R8", "alarm cleared on third edge", alarm_n, 1'b1);
            wait_neg(DEB + 4);
        end
    endtask

    initial begin
        void'($urandom(32'h00C0FFEE));
        wait_neg(3);
        rst_n = 1'b1;
        wait_neg(1);
        check("R10", "supply_en after reset", supply_en, 1'b0);
        check("R10", "io_en after reset", io_en, 1'b0);
        check("R10", "card_clk after reset", card_clk, 1'b0);
        check("R10", "card_rst after reset", card_rst, 1'b0);
        check("R10", "alarm_n after reset", alarm_n, 1'b1);

        // R1: command during the debounce window is dropped.
        card_present = 1'b1;
        wait_neg(DEB / 2);
        cmd_n = 1'b0;
        wait_neg(3 * STEP + DEB);
        check("R1", "early command ignored", supply_en, 1'b0);
        check("R9", "idle io_en", io_en, 1'b0);
        cmd_n = 1'b1;
        wait_neg(DEB + 4);

        // R9: fault present while idle blocks start, no alarm.
        flt_hot = 1'b1;
        wait_neg(3);
        cmd_n = 1'b0;
        wait_neg(8);
        check("R9", "start blocked by idle fault", supply_en, 1'b0);
        check("R9", "no alarm from idle fault", alarm_n, 1'b1);
        cmd_n = 1'b1;
        flt_hot = 1'b0;
        wait_neg(4);

        // R7: reset passthrough latency of two edges.
        rst_in = 1'b0;
        clk_sel = 1'b1;
        wait_neg(3);
        cmd_n = 1'b0;
        wait_neg(3 + 3 * STEP + 2);
        check("R7", "card_rst low with rst_in low", card_rst, 1'b0);
        rst_in = 1'b1;
        wait_neg(1);
        check("R7", "card_rst one edge after rise", card_rst, 1'b0);
        wait_neg(1);
        check("R7", "card_rst two edges after rise", card_rst, 1'b1);
        rst_in = 1'b0;
        wait_neg(1);
        check("R7", "card_rst one edge after fall", card_rst, 1'b1);
        wait_neg(1);
        check("R7", "card_rst two edges after fall", card_rst, 1'b0);
        cmd_n = 1'b1;
        wait_neg(3 + 4 * STEP + 2);
        check("R5", "supply off after release", supply_en, 1'b0);
        check("R8", "no alarm after host release", alarm_n, 1'b1);

        // Seeded random trials, plus the earliest and latest triggers.
        run_trial(0, 3, 1'b1, 1'b1);
        run_trial(2, 3 + 3 * STEP + 6, 1'b0, 1'b1);
        for (int t = 0; t < 40; t++) begin
            run_trial(int'($urandom_range(0, 5)),
                      int'($urandom_range(3, 3 + 3 * STEP + 6)),
                      logic'($urandom_range(0, 1)),
                      logic'($urandom_range(0, 1)));
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule